// File: doc/BRIEF.md
# Integer Register File with Aliased Views

This block holds the integer architectural state of a 64-bit core: a general register file of 64 entries, each 64 bits wide, a small bank of control registers, and the program counter. Two full-width read ports and one write port serve the execute stage. A 32-bit compatibility read path and a narrow write mode expose the low half of any register. A narrow write stores a sign-extended copy of the value.

Several named registers have no storage of their own. The global base, procedure and vector base registers, the multiply-accumulate halves and the T flag are fixed slices of ordinary general registers. A single alias write port updates them by read-modify-write. Control slot 0 is the 32-bit status register. Its S, Q and M bits can each be written alone through the same alias port. Entry 63 reads as zero.

A program counter write strips bit 0 of the written value into an instruction-set-mode flag. All state is cleared by an active-low asynchronous reset.

Top module: `int_regfile`

## Requirements
- R1: Reset clears every general register, control register, the status register, the program counter and the mode flag to zero.
- R2: Reading entry 63 through any read path returns zero. A write to entry 63 has no effect.
- R3: Read ports A and B return the full 64-bit register content. A write lands at the clock edge, so a read in the same cycle still returns the old value.
- R4: The compatibility read returns bits 31:0 of the selected register. A port write with `wr_narrow_i` high stores `wr_data_i[31:0]` sign-extended to 64 bits.
- R5: Control slot 0 reads as the status register zero-extended to 64 bits. A write to slot 0 stores only bits 31:0. Slots 1 to 7 are plain 64-bit storage.
- R6: GBR, PR and VBR are bits 31:0 of general registers 16, 18 and 20 (alias codes 0, 1 and 2). An alias write stores the 32-bit value sign-extended to 64 bits.
- R7: General register 17 holds MACH in bits 63:32 and MACL in bits 31:0 (alias codes 3 and 4). Writing one half keeps the other half.
- R8: The T flag is bit 0 of general register 19 (alias code 5, value taken from `alias_wdata_i[0]`). Writing it keeps bits 63:1.
- R9: Alias codes 6, 7 and 8 replace status bit 1 (S), bit 8 (Q) and bit 9 (M) with `alias_wdata_i[0]`. All other status bits are kept.
- R10: A program counter write stores the value with bit 0 cleared and copies bit 0 into the mode flag. The mode flag has no other write path.
- R11: When an alias write and a port write (or a control slot 0 write) hit the same register in one cycle, the alias result is stored and the port write is dropped. Alias codes 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_idx_i | input | 6 | Read port A index |
| ra_data_o | output | 64 | Read port A data |
| rb_idx_i | input | 6 | Read port B index |
| rb_data_o | output | 64 | Read port B data |
| rc_idx_i | input | 6 | Compatibility read index |
| rc_data_o | output | 32 | Compatibility read data (low half) |
| wr_en_i | input | 1 | Port write enable |
| wr_narrow_i | input | 1 | Write low 32 bits sign-extended |
| wr_idx_i | input | 6 | Port write index |
| wr_data_i | input | 64 | Port write data |
| alias_we_i | input | 1 | Alias write enable |
| alias_sel_i | input | 4 | Alias target code |
| alias_wdata_i | input | 32 | Alias write value |
| gbr_o | output | 32 | Global base view |
| pr_o | output | 32 | Procedure register view |
| vbr_o | output | 32 | Vector base view |
| mach_o | output | 32 | Multiply-accumulate high half |
| macl_o | output | 32 | Multiply-accumulate low half |
| t_o | output | 1 | T flag |
| cr_we_i | input | 1 | Control register write enable |
| cr_widx_i | input | 3 | Control write index |
| cr_wdata_i | input | 64 | Control write data |
| cr_ridx_i | input | 3 | Control read index |
| cr_rdata_o | output | 64 | Control read data |
| sr_o | output | 32 | Status register |
| pc_we_i | input | 1 | Program counter write enable |
| pc_wdata_i | input | 64 | Program counter write value |
| pc_o | output | 64 | Program counter |
| ism_o | output | 1 | Instruction-set-mode flag |

## Verification
The bench aims at the merge and extension corners, each of which fails in a visible way. A write to entry 63 that is not dropped makes a later read of 63 non-zero. A missing sign extension on a narrow or GBR/PR/VBR write leaves zeros in the upper half where a negative value needs ones. A half-word or bit write that does not merge from the old value wipes the MACL, MACH or upper T-register bits, or the neighbouring S/Q/M status bits. Same-cycle collisions of alias and port writes on register 17, and of status-bit and slot 0 writes, show whether priority is inverted. Odd program counter values show whether bit 0 is stripped into the mode flag.

// File: rtl/int_regfile_pkg.sv
package int_regfile_pkg;
  typedef enum logic [3:0] {
    AL_GBR  = 4'd0,
    AL_PR   = 4'd1,
    AL_VBR  = 4'd2,
    AL_MACH = 4'd3,
    AL_MACL = 4'd4,
    AL_TFLG = 4'd5,
    AL_SBIT = 4'd6,
    AL_QBIT = 4'd7,
    AL_MBIT = 4'd8
  } alias_sel_e;

  localparam int unsigned GBR_SLOT = 16;
  localparam int unsigned MAC_SLOT = 17;
  localparam int unsigned PR_SLOT  = 18;
  localparam int unsigned T_SLOT   = 19;
  localparam int unsigned VBR_SLOT = 20;

  localparam int unsigned SR_S_POS = 1;
  localparam int unsigned SR_Q_POS = 8;
  localparam int unsigned SR_M_POS = 9;
endpackage

// File: rtl/alias_map.sv
module alias_map
  import int_regfile_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 6,
  localparam int HW = DW / 2
) (
  input  logic          we_i,
  input  logic [3:0]    sel_i,
  input  logic [HW-1:0] wdata_i,
  input  logic [DW-1:0] mac_q_i,
  input  logic [DW-2:0] t_hi_i,
  input  logic [HW-1:0] sr_q_i,
  output logic          gr_we_o,
  output logic [IW-1:0] gr_idx_o,
  output logic [DW-1:0] gr_data_o,
  output logic          sr_we_o,
  output logic [HW-1:0] sr_data_o
);
  logic [DW-1:0] sext;
  assign sext = {{HW{wdata_i[HW-1]}}, wdata_i};

  always_comb begin
    gr_we_o   = 1'b0;
    gr_idx_o  = '0;
    gr_data_o = '0;
    sr_we_o   = 1'b0;
    sr_data_o = sr_q_i;
    if (we_i) begin
      case (alias_sel_e'(sel_i))
        AL_GBR:  begin gr_we_o = 1'b1; gr_idx_o = IW'(GBR_SLOT); gr_data_o = sext; end
        AL_PR:   begin gr_we_o = 1'b1; gr_idx_o = IW'(PR_SLOT);  gr_data_o = sext; end
        AL_VBR:  begin gr_we_o = 1'b1; gr_idx_o = IW'(VBR_SLOT); gr_data_o = sext; end
        AL_MACH: begin gr_we_o = 1'b1; gr_idx_o = IW'(MAC_SLOT);
                       gr_data_o = {wdata_i, mac_q_i[HW-1:0]}; end
        AL_MACL: begin gr_we_o = 1'b1; gr_idx_o = IW'(MAC_SLOT);
                       gr_data_o = {mac_q_i[DW-1:HW], wdata_i}; end
        AL_TFLG: begin gr_we_o = 1'b1; gr_idx_o = IW'(T_SLOT);
                       gr_data_o = {t_hi_i, wdata_i[0]}; end
        AL_SBIT: begin sr_we_o = 1'b1; sr_data_o[SR_S_POS] = wdata_i[0]; end
        AL_QBIT: begin sr_we_o = 1'b1; sr_data_o[SR_Q_POS] = wdata_i[0]; end
        AL_MBIT: begin sr_we_o = 1'b1; sr_data_o[SR_M_POS] = wdata_i[0]; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gr_file.sv
module gr_file #(
  parameter int NREG = 64,
  parameter int DW   = 64,
  localparam int IW  = $clog2(NREG),
  localparam int ZERO_IDX = NREG - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pwe_i,
  input  logic [IW-1:0]            pidx_i,
  input  logic [DW-1:0]            pdata_i,
  input  logic                     awe_i,
  input  logic [IW-1:0]            aidx_i,
  input  logic [DW-1:0]            adata_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == ZERO_IDX) begin : g_zero
      assign regs_o[i] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (awe_i && aidx_i == IW'(i))           q <= adata_i;
        else if (pwe_i && pidx_i == IW'(i))           q <= pdata_i;
      end
      assign regs_o[i] = q;
    end
  end

  // R3: an uncontested port write is visible after the edge
  a_r3_port_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwe_i && pidx_i != IW'(ZERO_IDX) && !(awe_i && aidx_i == pidx_i)
    |=> regs_o[$past(pidx_i)] == $past(pdata_i));

  // R11: alias write always wins
  a_r11_alias_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awe_i && aidx_i != IW'(ZERO_IDX) |=> regs_o[$past(aidx_i)] == $past(adata_i));
endmodule

// File: rtl/cr_bank.sv
module cr_bank #(
  parameter int NCR = 8,
  parameter int DW  = 64,
  localparam int CW = $clog2(NCR),
  localparam int HW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cwe_i,
  input  logic [CW-1:0] cwidx_i,
  input  logic [DW-1:0] cwdata_i,
  input  logic          bwe_i,
  input  logic [HW-1:0] bdata_i,
  input  logic [CW-1:0] cridx_i,
  output logic [DW-1:0] crdata_o,
  output logic [HW-1:0] sr_o
);
  logic [HW-1:0] sr_q;
  logic [NCR-1:0][DW-1:0] view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sr_q <= '0;
    else if (bwe_i)                   sr_q <= bdata_i;
    else if (cwe_i && cwidx_i == '0)  sr_q <= cwdata_i[HW-1:0];
  end

  assign view[0] = {{HW{1'b0}}, sr_q};

  for (genvar i = 1; i < NCR; i++) begin : g_cr
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (cwe_i && cwidx_i == CW'(i))  q <= cwdata_i;
    end
    assign view[i] = q;
  end

  assign crdata_o = view[cridx_i];
  assign sr_o     = sr_q;

  // R5: slot 0 write keeps only the low half
  a_r5_sr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwe_i && cwidx_i == '0 && !bwe_i |=> sr_o == $past(cwdata_i[HW-1:0]));

  // R9: status bit write takes the merged value
  a_r9_bit_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bwe_i |=> sr_o == $past(bdata_i));
endmodule

// File: rtl/int_regfile.sv
module int_regfile
  import int_regfile_pkg::*;
#(
  parameter int NREG = 64,
  parameter int DW   = 64,
  parameter int NCR  = 8,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NCR),
  localparam int HW  = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o,
  input  logic [IW-1:0] rc_idx_i,
  output logic [HW-1:0] rc_data_o,
  input  logic          wr_en_i,
  input  logic          wr_narrow_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          alias_we_i,
  input  logic [3:0]    alias_sel_i,
  input  logic [HW-1:0] alias_wdata_i,
  output logic [HW-1:0] gbr_o,
  output logic [HW-1:0] pr_o,
  output logic [HW-1:0] vbr_o,
  output logic [HW-1:0] mach_o,
  output logic [HW-1:0] macl_o,
  output logic          t_o,
  input  logic          cr_we_i,
  input  logic [CW-1:0] cr_widx_i,
  input  logic [DW-1:0] cr_wdata_i,
  input  logic [CW-1:0] cr_ridx_i,
  output logic [DW-1:0] cr_rdata_o,
  output logic [HW-1:0] sr_o,
  input  logic          pc_we_i,
  input  logic [DW-1:0] pc_wdata_i,
  output logic [DW-1:0] pc_o,
  output logic          ism_o
);
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0] port_data;
  logic          al_gr_we, al_sr_we;
  logic [IW-1:0] al_gr_idx;
  logic [DW-1:0] al_gr_data;
  logic [HW-1:0] al_sr_data;
  logic [DW-1:0] pc_q;
  logic          ism_q;

  assign port_data = wr_narrow_i ? {{HW{wr_data_i[HW-1]}}, wr_data_i[HW-1:0]} : wr_data_i;

  alias_map #(.DW(DW), .IW(IW)) u_alias (
    .we_i(alias_we_i), .sel_i(alias_sel_i), .wdata_i(alias_wdata_i),
    .mac_q_i(regs[MAC_SLOT]), .t_hi_i(regs[T_SLOT][DW-1:1]), .sr_q_i(sr_o),
    .gr_we_o(al_gr_we), .gr_idx_o(al_gr_idx), .gr_data_o(al_gr_data),
    .sr_we_o(al_sr_we), .sr_data_o(al_sr_data)
  );

  gr_file #(.NREG(NREG), .DW(DW)) u_gr (
    .clk_i, .rst_ni,
    .pwe_i(wr_en_i), .pidx_i(wr_idx_i), .pdata_i(port_data),
    .awe_i(al_gr_we), .aidx_i(al_gr_idx), .adata_i(al_gr_data),
    .regs_o(regs)
  );

  cr_bank #(.NCR(NCR), .DW(DW)) u_cr (
    .clk_i, .rst_ni,
    .cwe_i(cr_we_i), .cwidx_i(cr_widx_i), .cwdata_i(cr_wdata_i),
    .bwe_i(al_sr_we), .bdata_i(al_sr_data),
    .cridx_i(cr_ridx_i), .crdata_o(cr_rdata_o), .sr_o(sr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ism_q <= 1'b0;
    end else if (pc_we_i) begin
      pc_q  <= {pc_wdata_i[DW-1:1], 1'b0};
      ism_q <= pc_wdata_i[0];
    end
  end

  assign ra_data_o = regs[ra_idx_i];
  assign rb_data_o = regs[rb_idx_i];
  assign rc_data_o = regs[rc_idx_i][HW-1:0];
  assign gbr_o     = regs[GBR_SLOT][HW-1:0];
  assign pr_o      = regs[PR_SLOT][HW-1:0];
  assign vbr_o     = regs[VBR_SLOT][HW-1:0];
  assign mach_o    = regs[MAC_SLOT][DW-1:HW];
  assign macl_o    = regs[MAC_SLOT][HW-1:0];
  assign t_o       = regs[T_SLOT][0];
  assign pc_o      = pc_q;
  assign ism_o     = ism_q;

  // R2: the zero entry reads as zero on port A
  a_r2_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_idx_i == IW'(NREG - 1) |-> ra_data_o == '0);

  // R7: MACH write keeps MACL
  a_r7_mach_keeps_macl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_we_i && alias_sel_i == AL_MACH |=> macl_o == $past(macl_o));

  // R8: T write keeps upper bits of its host register
  a_r8_t_keeps_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_we_i && alias_sel_i == AL_TFLG
    |=> regs[T_SLOT][DW-1:1] == $past(regs[T_SLOT][DW-1:1]));

  // R10: PC bit 0 moves into the mode flag
  a_r10_pc_strip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_i |=> pc_o[0] == 1'b0 && pc_o[DW-1:1] == $past(pc_wdata_i[DW-1:1])
               && ism_o == $past(pc_wdata_i[0]));
endmodule

// File: tb/tb_int_regfile.sv
module tb_int_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  ra_idx_i = '0, rb_idx_i = '0, rc_idx_i = '0, wr_idx_i = '0;
  logic [63:0] ra_data_o, rb_data_o, wr_data_i = '0;
  logic [31:0] rc_data_o;
  logic        wr_en_i = 1'b0, wr_narrow_i = 1'b0;
  logic        alias_we_i = 1'b0;
  logic [3:0]  alias_sel_i = '0;
  logic [31:0] alias_wdata_i = '0;
  logic [31:0] gbr_o, pr_o, vbr_o, mach_o, macl_o, sr_o;
  logic        t_o, ism_o;
  logic        cr_we_i = 1'b0;
  logic [2:0]  cr_widx_i = '0, cr_ridx_i = '0;
  logic [63:0] cr_wdata_i = '0, cr_rdata_o;
  logic        pc_we_i = 1'b0;
  logic [63:0] pc_wdata_i = '0, pc_o;

  int n_run = 0, n_fail = 0;
  string ra_tag = "";

  logic [63:0] m_gr [64];
  logic [63:0] m_cr [8];
  logic [31:0] m_sr;
  logic [63:0] m_pc;
  logic        m_ism;

  always #2 clk_i = ~clk_i;

  int_regfile dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] rd(logic [5:0] i);
    return (i == 6'd63) ? 64'd0 : m_gr[i];
  endfunction

  task automatic idle();
    wr_en_i = 0; wr_narrow_i = 0; alias_we_i = 0; cr_we_i = 0; pc_we_i = 0;
  endtask

  // check outputs against the model, then advance the model over one edge
  task automatic cycle();
    logic [63:0] ngr [64];
    logic [63:0] ncr [8];
    logic [31:0] nsr;
    logic [63:0] npc;
    logic        nism, agr, asr;
    logic [5:0]  aidx;
    logic [63:0] aval;
    #1;
    chk(ra_tag == "" ? "R3 ra" : ra_tag, ra_data_o, rd(ra_idx_i));
    ra_tag = "";
    chk("R3 rb", rb_data_o, rd(rb_idx_i));
    chk("R4 rc", {32'd0, rc_data_o}, {32'd0, rd(rc_idx_i)[31:0]});
    chk("R5 cr", cr_rdata_o, cr_ridx_i == 0 ? {32'd0, m_sr} : m_cr[cr_ridx_i]);
    chk("R6 gbr", {32'd0, gbr_o}, {32'd0, m_gr[16][31:0]});
    chk("R6 pr", {32'd0, pr_o}, {32'd0, m_gr[18][31:0]});
    chk("R6 vbr", {32'd0, vbr_o}, {32'd0, m_gr[20][31:0]});
    chk("R7 mac", {mach_o, macl_o}, m_gr[17]);
    chk("R8 t", {63'd0, t_o}, {63'd0, m_gr[19][0]});
    chk("R9 sr", {32'd0, sr_o}, {32'd0, m_sr});
    chk("R10 pc", pc_o, m_pc);
    chk("R10 ism", {63'd0, ism_o}, {63'd0, m_ism});
    ngr = m_gr; ncr = m_cr; nsr = m_sr; npc = m_pc; nism = m_ism;
    agr = 0; asr = 0; aidx = 0; aval = 0;
    if (alias_we_i) begin
      case (alias_sel_i)
        4'd0: begin agr = 1; aidx = 16; aval = sx(alias_wdata_i); end
        4'd1: begin agr = 1; aidx = 18; aval = sx(alias_wdata_i); end
        4'd2: begin agr = 1; aidx = 20; aval = sx(alias_wdata_i); end
        4'd3: begin agr = 1; aidx = 17; aval = {alias_wdata_i, m_gr[17][31:0]}; end
        4'd4: begin agr = 1; aidx = 17; aval = {m_gr[17][63:32], alias_wdata_i}; end
        4'd5: begin agr = 1; aidx = 19; aval = {m_gr[19][63:1], alias_wdata_i[0]}; end
        4'd6: begin asr = 1; nsr[1] = alias_wdata_i[0]; end
        4'd7: begin asr = 1; nsr[8] = alias_wdata_i[0]; end
        4'd8: begin asr = 1; nsr[9] = alias_wdata_i[0]; end
        default: ;
      endcase
    end
    if (wr_en_i && wr_idx_i != 6'd63 && !(agr && aidx == wr_idx_i))
      ngr[wr_idx_i] = wr_narrow_i ? sx(wr_data_i[31:0]) : wr_data_i;
    if (agr) ngr[aidx] = aval;
    if (cr_we_i) begin
      if (cr_widx_i == 0) begin
        if (!asr) nsr = cr_wdata_i[31:0];
      end else ncr[cr_widx_i] = cr_wdata_i;
    end
    if (pc_we_i) begin npc = {pc_wdata_i[63:1], 1'b0}; nism = pc_wdata_i[0]; end
    @(posedge clk_i);
    if (rst_ni) begin
      m_gr = ngr; m_cr = ncr; m_sr = nsr; m_pc = npc; m_ism = nism;
    end
    @(negedge clk_i);
  endtask

  function automatic logic [5:0] pick_idx();
    int r = $urandom % 8;
    if (r < 3) return 6'(16 + $urandom % 5);
    if (r == 3) return 6'd63;
    return 6'($urandom % 64);
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) m_gr[i] = '0;
    for (int i = 0; i < 8; i++) m_cr[i] = '0;
    m_sr = '0; m_pc = '0; m_ism = 0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    // R1: everything zero after reset
    for (int i = 0; i < 64; i++) begin
      ra_idx_i = 6'(i); cr_ridx_i = 3'(i % 8); ra_tag = "R1 reset";
      cycle();
    end
    // R2: write to 63 is dropped
    wr_en_i = 1; wr_idx_i = 63; wr_data_i = '1; cycle();
    idle(); ra_idx_i = 63; ra_tag = "R2 zero"; cycle();
    // R3: same-cycle read returns old value, then new
    wr_en_i = 1; wr_idx_i = 5; wr_data_i = 64'h0123_4567_89ab_cdef; ra_idx_i = 5; cycle();
    idle(); cycle();
    // R4: narrow write sign-extends
    wr_en_i = 1; wr_narrow_i = 1; wr_idx_i = 7; wr_data_i = 64'h1111_1111_8000_0001; cycle();
    idle(); ra_idx_i = 7; ra_tag = "R4 sext"; cycle();
    // R6: negative GBR write
    alias_we_i = 1; alias_sel_i = 0; alias_wdata_i = 32'hf000_0002; cycle();
    idle(); ra_idx_i = 16; ra_tag = "R6 gbr sext"; cycle();
    // R7: fill 17, then write halves
    wr_en_i = 1; wr_idx_i = 17; wr_data_i = 64'haaaa_bbbb_cccc_dddd; cycle();
    idle(); alias_we_i = 1; alias_sel_i = 3; alias_wdata_i = 32'h1234_5678; cycle();
    alias_sel_i = 4; alias_wdata_i = 32'h9abc_def0; cycle();
    idle(); ra_idx_i = 17; ra_tag = "R7 halves"; cycle();
    // R11: alias and port write collide on 17
    wr_en_i = 1; wr_idx_i = 17; wr_data_i = '1;
    alias_we_i = 1; alias_sel_i = 4; alias_wdata_i = 32'h0000_0042; cycle();
    idle(); ra_idx_i = 17; ra_tag = "R11 prio"; cycle();
    // R8: T flag on a full host register
    wr_en_i = 1; wr_idx_i = 19; wr_data_i = 64'hffff_0000_ffff_fffe; cycle();
    idle(); alias_we_i = 1; alias_sel_i = 5; alias_wdata_i = 1; cycle();
    idle(); ra_idx_i = 19; ra_tag = "R8 tbit"; cycle();
    // R9/R11: status bits over slot 0 write
    cr_we_i = 1; cr_widx_i = 0; cr_wdata_i = 64'hdead_beef_0000_0000; cycle();
    alias_we_i = 1; alias_sel_i = 8; alias_wdata_i = 1; cr_wdata_i = '1; cycle();
    idle(); alias_we_i = 1; alias_sel_i = 6; alias_wdata_i = 1; cycle();
    alias_sel_i = 9; alias_wdata_i = '1; cycle();
    idle(); cr_ridx_i = 0; cycle();
    // R10: odd PC
    pc_we_i = 1; pc_wdata_i = 64'h8000_0000_0000_1235; cycle();
    pc_wdata_i = 64'h0000_0000_0000_4000; cycle();
    idle(); cycle();
    // random mix
    for (int k = 0; k < 4000; k++) begin
      ra_idx_i = pick_idx(); rb_idx_i = pick_idx(); rc_idx_i = pick_idx();
      wr_en_i = ($urandom % 2) == 0; wr_narrow_i = ($urandom % 3) == 0;
      wr_idx_i = pick_idx(); wr_data_i = {$urandom, $urandom};
      alias_we_i = ($urandom % 2) == 0; alias_sel_i = 4'($urandom % 16);
      alias_wdata_i = $urandom;
      cr_we_i = ($urandom % 3) == 0; cr_widx_i = 3'($urandom % 8);
      cr_wdata_i = {$urandom, $urandom}; cr_ridx_i = 3'($urandom % 8);
      pc_we_i = ($urandom % 4) == 0; pc_wdata_i = {$urandom, $urandom};
      cycle();
    end
    idle(); cycle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule